// File: doc/BRIEF.md
# Dilated Router Output-Port Arbiter

This block allocates output ports inside one circuit-switched routing element that steers four logical directions, each backed by two redundant physical ports, for eight inputs and eight outputs in all. An input that wants to open a connection raises its request and presents its message header. The arbiter takes the two-bit routing digit that belongs to this stage, which fixes the logical direction. It then picks one of the two physical ports of that direction, or it answers busy when neither port can take the connection.

The pick weighs three things for each port: whether it already carries a connection, whether it is operational, and whether the router behind it reports itself blocked. A free-running pseudo-random source settles ties. Requests are served one per cycle in rotating order, and the answer comes back in the same cycle. Released ports become free on the next clock edge. The arbiter also derives its own blocked flag for the stage in front of it. A mode input splits the element into two independent four-input routers with a single port per direction.

Top module: `dil_port_arb`

## Requirements
- R1: After reset no port is in use, the rotation pointer is at input 0 and the random source holds 16'hACE1. With every port operational and no downstream blocking, no response is given and both blocked bits are 0.
- R2: With default parameters (8-bit header, stage 1), the direction is header bits [5:4]; stage s uses the two bits starting at bit 7-2s, most significant first. Direction d owns physical ports 2d (offset 0) and 2d+1 (offset 1); no other header bit affects the choice.
- R3: A port that carries a connection is never granted again until released. When exactly one port of the direction is unused and operational, that port is granted, even if its downstream router is blocked.
- R4: When both ports of the direction are unused and operational and exactly one has its downstream-blocked input high, the other port is granted.
- R5: When both ports are unused and operational and their downstream-blocked inputs are equal, the granted offset is bit 0 of a 16-bit shift register. The register shifts left once per clock, with new bit = q[15]^q[13]^q[12]^q[10].
- R6: When no port of the direction is unused and operational, the response is busy in the same cycle, and no port state changes.
- R7: One response per cycle. The served input is the first requesting input found counting upward (wrapping) from the pointer, and the pointer then moves to the served input plus one.
- R8: A release pulse on a port frees it at the next clock edge; a request in the release cycle still sees the port as used.
- R9: In normal mode both bits of blk_o equal 1 when some direction has no port that is unused, operational and not downstream-blocked.
- R10: In split mode inputs 0-3 may only use even ports and inputs 4-7 only odd ports (offset = input bit 2). blk_o[h] covers half h alone.
- R11: A port whose operational input is low is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| split_i | input | 1 | 1 = two independent four-input routers |
| req_i | input | 8 | Connection request per input |
| hdr_i | input | 64 | Header per input, input i at bits [8i+7:8i] |
| port_ok_i | input | 8 | Operational status per output port |
| dn_blk_i | input | 8 | Downstream router blocked, per output port |
| rel_i | input | 8 | Release pulse per output port |
| resp_valid_o | output | 1 | A request is answered this cycle |
| resp_busy_o | output | 1 | The answered request was refused |
| resp_in_o | output | 3 | Index of the answered input |
| resp_port_o | output | 3 | Granted port (0 when busy) |
| blk_o | output | 2 | Blocked flag, one bit per half |

## Verification
A stale or lost in-use bit shows at the ports as soon as the next request names that direction. Depending on which way the bit is wrong, the port is granted twice, the request is refused wrongly, or the wrong port is picked. The blocked flag shows it in the same cycle. A rotation pointer that drifts serves the wrong input on the first cycle in which two inputs contend. A random source out of step shows at the next tie. The bench follows all three pieces of state in a model built from the requirements and checks every response and the blocked flag in every checked cycle.

// File: rtl/dil_arb_pkg.sv
package dil_arb_pkg;
    localparam int DIL = 2;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] q);
        return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
    endfunction
endpackage

// File: rtl/dil_arb_lfsr.sv
module dil_arb_lfsr
    import dil_arb_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    output logic [LFSR_W-1:0] q_o
);
    logic [LFSR_W-1:0] q_d, q_q;

    always_comb begin
        q_d = lfsr_next(q_q);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q_q <= LFSR_SEED;
        else         q_q <= q_d;
    end

    assign q_o = q_q;
endmodule

// File: rtl/dil_arb_rr.sv
module dil_arb_rr #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] ptr_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int off = 0; off < N; off++) begin
            int j;
            j = (int'(ptr_i) + off) % N;
            if (!hit_o && req_i[j]) begin
                hit_o = 1'b1;
                idx_o = IW'(j);
            end
        end
    end
endmodule

// File: rtl/dil_arb_pair_pick.sv
module dil_arb_pair_pick (
    input  logic [1:0] elig_i,
    input  logic [1:0] dblk_i,
    input  logic       coin_i,
    output logic       found_o,
    output logic       k_o
);
    always_comb begin
        found_o = |elig_i;
        k_o     = 1'b0;
        unique case (elig_i)
            2'b01:   k_o = 1'b0;
            2'b10:   k_o = 1'b1;
            2'b11:   k_o = (dblk_i[0] != dblk_i[1]) ? dblk_i[0] : coin_i;
            default: k_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dil_port_arb.sv
module dil_port_arb
    import dil_arb_pkg::*;
#(
    parameter int RADIX = 4,
    parameter int HDR_W = 8,
    parameter int STAGE = 1,
    localparam int DIG_W  = $clog2(RADIX),
    localparam int N_PORT = RADIX * DIL,
    localparam int N_IN   = N_PORT,
    localparam int IN_W   = $clog2(N_IN),
    localparam int P_W    = $clog2(N_PORT),
    localparam int DIG_LSB = HDR_W - DIG_W * (STAGE + 1)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    split_i,
    input  logic [N_IN-1:0]         req_i,
    input  logic [N_IN*HDR_W-1:0]   hdr_i,
    input  logic [N_PORT-1:0]       port_ok_i,
    input  logic [N_PORT-1:0]       dn_blk_i,
    input  logic [N_PORT-1:0]       rel_i,
    output logic                    resp_valid_o,
    output logic                    resp_busy_o,
    output logic [IN_W-1:0]         resp_in_o,
    output logic [P_W-1:0]          resp_port_o,
    output logic [1:0]              blk_o
);
    typedef struct packed {
        logic [N_PORT-1:0] used;
        logic [IN_W-1:0]   rr;
    } state_t;

    state_t st_d, st_q;

    logic [LFSR_W-1:0] rnd;
    logic              hit;
    logic [IN_W-1:0]   sel;
    logic [DIG_W-1:0]  dir;
    logic [DIL-1:0]    elig, cblk;
    logic [P_W-1:0]    cport [DIL];
    logic              found, k;
    logic [P_W-1:0]    gport;

    dil_arb_lfsr u_lfsr (.clk_i(clk_i), .rst_ni(rst_ni), .q_o(rnd));

    dil_arb_rr #(.N(N_IN)) u_rr (
        .req_i (req_i),
        .ptr_i (st_q.rr),
        .hit_o (hit),
        .idx_o (sel)
    );

    assign dir = hdr_i[int'(sel) * HDR_W + DIG_LSB +: DIG_W];

    // candidate ports of the selected direction
    for (genvar g = 0; g < DIL; g++) begin : g_cand
        assign cport[g] = {dir, 1'(g)};
        assign elig[g]  = !st_q.used[cport[g]] && port_ok_i[cport[g]]
                          && (!split_i || (sel[IN_W-1] == 1'(g)));
        assign cblk[g]  = dn_blk_i[cport[g]];
    end

    dil_arb_pair_pick u_pick (
        .elig_i  (elig),
        .dblk_i  (cblk),
        .coin_i  (rnd[0]),
        .found_o (found),
        .k_o     (k)
    );

    assign gport = {dir, k};

    // blocked flag: per direction, does a usable unblocked port remain
    logic [N_PORT-1:0] avail;
    logic [RADIX-1:0]  dir_any, half0, half1;

    assign avail = ~st_q.used & port_ok_i & ~dn_blk_i;

    for (genvar d = 0; d < RADIX; d++) begin : g_dir
        assign dir_any[d] = |avail[d*DIL +: DIL];
        assign half0[d]   = avail[d*DIL];
        assign half1[d]   = avail[d*DIL + 1];
    end

    always_comb begin
        st_d      = st_q;
        st_d.used = st_q.used & ~rel_i;
        if (hit && found) begin
            st_d.used[gport] = 1'b1;
        end
        if (hit) begin
            st_d.rr = (int'(sel) == N_IN - 1) ? '0 : sel + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign resp_valid_o = hit;
    assign resp_busy_o  = hit && !found;
    assign resp_in_o    = sel;
    assign resp_port_o  = found ? gport : '0;
    assign blk_o        = split_i ? {~&half1, ~&half0} : {2{~&dir_any}};
endmodule

// File: rtl/dil_port_arb_chk.sv
module dil_port_arb_chk #(
    parameter int N_IN  = 8,
    parameter int HDR_W = 8,
    parameter int DIG_W = 2,
    parameter int DIG_LSB = 4,
    localparam int IN_W = $clog2(N_IN),
    localparam int P_W  = $clog2(N_IN)
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  split_i,
    input logic [N_IN-1:0]       req_i,
    input logic [N_IN*HDR_W-1:0] hdr_i,
    input logic [N_IN-1:0]       port_ok_i,
    input logic [N_IN-1:0]       rel_i,
    input logic                  resp_valid_o,
    input logic                  resp_busy_o,
    input logic [IN_W-1:0]       resp_in_o,
    input logic [P_W-1:0]        resp_port_o
);
    logic            gnt;
    logic            live_q, pgnt_q;
    logic [P_W-1:0]  pport_q;
    logic [N_IN-1:0] prel_q;

    assign gnt = resp_valid_o && !resp_busy_o;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            live_q  <= 1'b0;
            pgnt_q  <= 1'b0;
            pport_q <= '0;
            prel_q  <= '0;
        end else begin
            live_q  <= 1'b1;
            pgnt_q  <= gnt;
            pport_q <= resp_port_o;
            prel_q  <= rel_i;
        end
    end

    // R7
    served_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resp_valid_o |-> req_i[resp_in_o]);

    // R7
    answer_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|req_i) |-> resp_valid_o);

    // R2
    dir_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt |-> (resp_port_o[P_W-1:1] == hdr_i[int'(resp_in_o)*HDR_W + DIG_LSB +: DIG_W]));

    // R11
    oper_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt |-> port_ok_i[resp_port_o]);

    // R10
    split_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (split_i && gnt) |-> (resp_port_o[0] == resp_in_o[IN_W-1]));

    // R3
    no_regrant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && gnt && pgnt_q && resp_port_o == pport_q) |-> prel_q[pport_q]);
endmodule

bind dil_port_arb dil_port_arb_chk #(
    .N_IN(N_IN), .HDR_W(HDR_W), .DIG_W(DIG_W), .DIG_LSB(DIG_LSB)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .split_i(split_i), .req_i(req_i),
    .hdr_i(hdr_i), .port_ok_i(port_ok_i), .rel_i(rel_i),
    .resp_valid_o(resp_valid_o), .resp_busy_o(resp_busy_o),
    .resp_in_o(resp_in_o), .resp_port_o(resp_port_o)
);

// File: tb/dil_port_arb_test.sv
`timescale 1ns/1ps
module dil_port_arb_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       split = 1'b0;
    logic [7:0] req = '0;
    logic [7:0] hdr_a [8];
    logic [63:0] hdr_flat;
    logic [7:0] ok = 8'hFF;
    logic [7:0] dblk = '0;
    logic [7:0] rel = '0;
    logic       r_valid, r_busy;
    logic [2:0] r_in, r_port;
    logic [1:0] r_blk;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) hdr_flat[i*8 +: 8] = hdr_a[i];
    end

    dil_port_arb uut (
        .clk_i(clk), .rst_ni(rst_n), .split_i(split), .req_i(req),
        .hdr_i(hdr_flat), .port_ok_i(ok), .dn_blk_i(dblk), .rel_i(rel),
        .resp_valid_o(r_valid), .resp_busy_o(r_busy), .resp_in_o(r_in),
        .resp_port_o(r_port), .blk_o(r_blk)
    );

    typedef struct packed {
        logic       v;
        logic       b;
        logic [2:0] in;
        logic [2:0] port;
        logic [1:0] blk;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];
    int    total = 0;
    int    bad = 0;
    bit    finished = 0;

    // reference state built from the requirements
    logic [7:0]  m_used = '0;
    logic [2:0]  m_rr = '0;
    logic [15:0] m_lfsr = 16'hACE1;

    function automatic logic [7:0] H(input logic [1:0] d, input logic [5:0] noise);
        return {noise[5:4], d, noise[3:0]};
    endfunction

    function automatic exp_t predict();
        exp_t e;
        int   srv;
        logic [1:0] d;
        logic [1:0] el;
        logic [1:0] ab;
        logic k;
        e = '0;
        srv = -1;
        for (int off = 0; off < 8; off++) begin
            int j;
            j = (int'(m_rr) + off) % 8;
            if (srv < 0 && req[j]) srv = j;
        end
        if (srv >= 0) begin
            e.v  = 1'b1;
            e.in = 3'(srv);
            d = hdr_a[srv][5:4];
            for (int kk = 0; kk < 2; kk++) begin
                int p;
                p = d * 2 + kk;
                el[kk] = !m_used[p] && ok[p] && (!split || (kk == (srv / 4)));
                ab[kk] = dblk[p];
            end
            if (el == 2'b00) begin
                e.b = 1'b1;
            end else begin
                if (el == 2'b01)      k = 1'b0;
                else if (el == 2'b10) k = 1'b1;
                else if (ab[0] && !ab[1]) k = 1'b1;
                else if (ab[1] && !ab[0]) k = 1'b0;
                else k = m_lfsr[0];
                e.port = {d, k};
            end
        end
        for (int dd = 0; dd < 4; dd++) begin
            bit a0, a1;
            a0 = !m_used[dd*2]   && ok[dd*2]   && !dblk[dd*2];
            a1 = !m_used[dd*2+1] && ok[dd*2+1] && !dblk[dd*2+1];
            if (split) begin
                if (!a0) e.blk[0] = 1'b1;
                if (!a1) e.blk[1] = 1'b1;
            end else if (!a0 && !a1) begin
                e.blk = 2'b11;
            end
        end
        return e;
    endfunction

    // driver: one clock per call, inputs set by the caller at the falling edge
    task automatic cyc(input string tag);
        exp_t e;
        #1;
        e = predict();
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
        m_used = m_used & ~rel;
        if (e.v) begin
            if (!e.b) m_used[e.port] = 1'b1;
            m_rr = e.in + 3'd1;
        end
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        @(negedge clk);
        if (e.v) req[e.in] = 1'b0;
        rel = '0;
    endtask

    // monitor: compares the design against the queued expectation
    always begin
        @(negedge clk);
        #3;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            bit    wrong;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            wrong = (r_valid !== e.v) || (r_blk !== e.blk);
            if (e.v) wrong = wrong || (r_in !== e.in) || (r_busy !== e.b)
                             || (!e.b && r_port !== e.port);
            if (wrong) begin
                bad++;
                $display("FAIL %s: got v=%b busy=%b in=%0d port=%0d blk=%b, expected v=%b busy=%b in=%0d port=%0d blk=%b",
                         t, r_valid, r_busy, r_in, r_port, r_blk, e.v, e.b, e.in, e.port, e.blk);
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) hdr_a[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cyc("R1 idle after reset");

        hdr_a[3] = H(2'd2, 6'h2A); req[3] = 1'b1;
        cyc("R2 R5 tie in direction 2");
        hdr_a[5] = H(2'd2, 6'h15); req[5] = 1'b1;
        cyc("R3 remaining unused port");
        hdr_a[6] = H(2'd2, 6'h3F); req[6] = 1'b1;
        cyc("R6 busy on full direction");
        cyc("R9 blocked with direction 2 full");

        rel[4] = 1'b1; req[6] = 1'b1;
        cyc("R8 release not visible in same cycle");
        req[6] = 1'b1;
        cyc("R8 freed port granted");
        rel = 8'h30;
        cyc("R8 release both");

        dblk[0] = 1'b1; hdr_a[1] = H(2'd0, 6'h00); req[1] = 1'b1;
        cyc("R4 avoid downstream-blocked port");
        hdr_a[2] = H(2'd0, 6'h11); req[2] = 1'b1;
        cyc("R3 blocked port taken when only one unused");
        rel = 8'h03; dblk = 8'h03;
        cyc("R9 blocked direction 0");

        for (int n = 0; n < 6; n++) begin
            hdr_a[n] = H(2'(n % 4), 6'(n * 7)); req[n] = 1'b1;
            cyc("R5 tie pattern");
            rel = 8'hFF;
            cyc("R8 release after tie");
        end
        dblk = '0;

        ok[2] = 1'b0; hdr_a[0] = H(2'd1, 6'h09); req[0] = 1'b1;
        cyc("R11 non-operational port skipped");
        hdr_a[4] = H(2'd1, 6'h21); req[4] = 1'b1;
        cyc("R11 R6 busy with dead and used port");
        rel[3] = 1'b1; ok[2] = 1'b1;
        cyc("R8 release port 3");

        hdr_a[2] = H(2'd3, 6'h05); hdr_a[5] = H(2'd0, 6'h06); hdr_a[7] = H(2'd1, 6'h07);
        req[2] = 1'b1; req[5] = 1'b1; req[7] = 1'b1;
        cyc("R7 rotation first");
        cyc("R7 rotation second");
        cyc("R7 rotation third");
        rel = 8'hFF;
        cyc("R8 release all");

        split = 1'b1;
        hdr_a[1] = H(2'd3, 6'h12); req[1] = 1'b1;
        cyc("R10 lower half uses even port");
        hdr_a[5] = H(2'd3, 6'h34); req[5] = 1'b1;
        cyc("R10 upper half uses odd port");
        hdr_a[6] = H(2'd3, 6'h01); req[6] = 1'b1;
        cyc("R10 busy although even port of other half");
        rel[6] = 1'b1;
        cyc("R10 R9 release in lower half");
        cyc("R10 R9 per-half blocked flag");
        rel = 8'hFF;
        cyc("R10 release all");
        split = 1'b0;
        cyc("R1 R9 clear after full release");

        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule